// File: doc/BRIEF.md
# Pipelined Complex Correlation Accumulator

This block is the arithmetic core of a correlation engine. It has several independent channels. On every clock each channel can accept a pair of complex samples, `a` and `b`. Each part of a sample is a signed 8-bit integer, and the in-phase and quadrature parts arrive side by side. The channel multiplies `a` by the conjugate of `b` with four small multipliers. It then adds the complex product into an accumulator picked by a per-sample address. Feeding `b = a` gives autocorrelation. Feeding two different streams gives cross-correlation.

The accumulators are the whole result memory. Each lag or range cell has its own address, and the memory is updated by read-modify-write. Each sample carries a small control word: a valid bit, a clear bit and an address. Each field travels down its own delay chain, so it reaches its stage together with its own data. A clear bit starts a new integration period by writing the product in place of the sum. A forwarding path keeps accumulation exact when nearby samples target the same address. A sticky flag reports when a sum has gone past the signed range of the accumulator.

Top module: `cplx_corr_acc`

## Requirements
- R1: After a synchronous reset, `res_vld` is 0 and `ovf_flag` is 0 on every channel.
- R2: A sample presented with `in_vld` = 1 before rising edge E gives exactly one result with `res_vld` = 1 and `res_addr` equal to its address. That result shows on the outputs just after edge E+3.
- R3: The product is `a` times the conjugate of `b`. The real part is `a_re*b_re + a_im*b_im` and the imaginary part is `a_im*b_re - a_re*b_im`. All operands are two's complement 8-bit values, and the results are sign-extended to ACC_W bits.
- R4: With `in_clr` = 1, the reported and stored value is the product alone, whatever the address held before. Such a sample never raises `ovf_flag`.
- R5: With `in_clr` = 0, the reported and stored value is the earlier value at that address plus the product. This holds for samples any number of cycles apart, including gaps of three or more cycles.
- R6: Samples to the same address one cycle apart or two cycles apart accumulate exactly as if they were widely spaced.
- R7: One sample per clock is sustained. A run of samples to distinct addresses produces one result per clock, in order.
- R8: When either the real or the imaginary sum falls outside the signed ACC_W range, the stored and reported value wraps modulo 2^ACC_W. `ovf_flag` of that channel then goes to 1 at the same time as the result, and it stays at 1 until reset.
- R9: Channels are independent. Data, addresses, clears and overflow on one channel never change the results or the flag of another channel.
- R10: A cycle with `in_vld` = 0 produces no result three edges later, and it leaves every stored accumulator unchanged, whatever the values on the other inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | NCH | Per-channel sample valid |
| in_clr | input | NCH | Per-channel clear: load the product instead of adding it |
| in_addr | input | NCH x ADDR_W | Per-channel accumulator address |
| in_a_re | input | NCH x DW | Sample a, in-phase part (signed) |
| in_a_im | input | NCH x DW | Sample a, quadrature part (signed) |
| in_b_re | input | NCH x DW | Sample b, in-phase part (signed) |
| in_b_im | input | NCH x DW | Sample b, quadrature part (signed) |
| res_vld | output | NCH | Result valid |
| res_addr | output | NCH x ADDR_W | Address the result was written to |
| res_re | output | NCH x ACC_W | New accumulator value, real part (signed) |
| res_im | output | NCH x ACC_W | New accumulator value, imaginary part (signed) |
| ovf_flag | output | NCH | Sticky accumulator overflow flag |

## Verification
Two things can fall in the same cycle. One is a result memory read for a new sample. The other is a write, or a write that is still pending, from the one or two samples just ahead of it to the same address. The bench provokes this with runs of back-to-back and alternating-address accumulations, and it also drives overflow through such a run. It judges every result against a sequential model that treats each sample as a complete read-add-write before the next one. Any stale read therefore shows up as a wrong sum on `res_re` or `res_im`.

// File: rtl/cca_pkg.sv
package cca_pkg;
  // Stage numbering of the datapath; stage 0 is the input edge.
  localparam int ST_IN  = 1;  // operands registered
  localparam int ST_MUL = 2;  // four partial products registered
  localparam int ST_CMB = 3;  // complex product combined, memory word read
  localparam int ST_ACC = 4;  // new sum registered and reported
  localparam int ST_WB  = 5;  // sum written, kept for forwarding

  // Signed add overflow from the sign bits of both operands and the result.
  function automatic logic sgn_add_ovf(input logic a_s, input logic b_s, input logic r_s);
    return (a_s == b_s) && (r_s != a_s);
  endfunction
endpackage

// File: rtl/cca_delay.sv
module cca_delay #(
  parameter int W  = 1,
  parameter int N  = 2,
  parameter int LO = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [W-1:0]            d,
  output logic [N-LO-1:0][W-1:0]  q
);
  logic [N-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < N; i++) chain[i] <= chain[i-1];
    end
  end

  generate
    for (genvar g = 0; g < N - LO; g++) begin : g_tap
      assign q[g] = chain[g + LO];
    end
  endgenerate
endmodule

// File: rtl/cca_prod.sv
module cca_prod #(
  parameter int DW    = 8,
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    in_en,
  input  logic                    s1_en,
  input  logic                    s2_en,
  input  logic signed [DW-1:0]    a_re,
  input  logic signed [DW-1:0]    a_im,
  input  logic signed [DW-1:0]    b_re,
  input  logic signed [DW-1:0]    b_im,
  output logic signed [ACC_W-1:0] p_re,
  output logic signed [ACC_W-1:0] p_im
);
  localparam int PW  = 2 * DW;
  localparam int NMUL = 4;

  logic signed [DW-1:0] ar_q, ai_q, br_q, bi_q;
  logic signed [DW-1:0] lhs [NMUL];
  logic signed [DW-1:0] rhs [NMUL];
  logic signed [PW-1:0] mq  [NMUL];

  always_ff @(posedge clk) begin
    if (in_en) begin
      ar_q <= a_re;
      ai_q <= a_im;
      br_q <= b_re;
      bi_q <= b_im;
    end
  end

  // Multiplier operands: 0 = ii, 1 = qq, 2 = qi, 3 = iq
  assign lhs[0] = ar_q;  assign rhs[0] = br_q;
  assign lhs[1] = ai_q;  assign rhs[1] = bi_q;
  assign lhs[2] = ai_q;  assign rhs[2] = br_q;
  assign lhs[3] = ar_q;  assign rhs[3] = bi_q;

  generate
    for (genvar g = 0; g < NMUL; g++) begin : g_mul
      always_ff @(posedge clk) begin
        if (s1_en) mq[g] <= PW'(lhs[g]) * PW'(rhs[g]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (s2_en) begin
      p_re <= ACC_W'(mq[0]) + ACC_W'(mq[1]);
      p_im <= ACC_W'(mq[2]) - ACC_W'(mq[3]);
    end
  end
endmodule

// File: rtl/cca_accum.sv
module cca_accum
  import cca_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int ACC_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic                    s3_vld,
  input  logic                    s3_clr,
  input  logic [ADDR_W-1:0]       s3_addr,
  input  logic signed [ACC_W-1:0] p_re,
  input  logic signed [ACC_W-1:0] p_im,
  input  logic                    s4_vld,
  input  logic [ADDR_W-1:0]       s4_addr,
  input  logic                    s5_vld,
  input  logic [ADDR_W-1:0]       s5_addr,
  output logic signed [ACC_W-1:0] res_re,
  output logic signed [ACC_W-1:0] res_im,
  output logic                    ovf
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MW    = 2 * ACC_W;
  localparam int MSB   = ACC_W - 1;

  logic [MW-1:0] mem [DEPTH];
  logic [MW-1:0] rd_q;
  logic signed [ACC_W-1:0] wb_re, wb_im;
  logic signed [ACC_W-1:0] base_re, base_im, sum_re, sum_im;
  logic hit4, hit5, ovf_re, ovf_im;

  // Result memory: one synchronous read port, one write port
  always_ff @(posedge clk) begin
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (s4_vld) mem[s4_addr] <= {res_re, res_im};
  end

  // Copy of the word written last edge, which the read just missed
  always_ff @(posedge clk) begin
    wb_re <= res_re;
    wb_im <= res_im;
  end

  assign hit4 = s4_vld && (s4_addr == s3_addr);
  assign hit5 = s5_vld && (s5_addr == s3_addr);

  always_comb begin
    if (hit4) begin
      base_re = res_re;
      base_im = res_im;
    end else if (hit5) begin
      base_re = wb_re;
      base_im = wb_im;
    end else begin
      base_re = $signed(rd_q[MW-1:ACC_W]);
      base_im = $signed(rd_q[ACC_W-1:0]);
    end
  end

  assign sum_re = base_re + p_re;
  assign sum_im = base_im + p_im;
  assign ovf_re = !s3_clr && sgn_add_ovf(base_re[MSB], p_re[MSB], sum_re[MSB]);
  assign ovf_im = !s3_clr && sgn_add_ovf(base_im[MSB], p_im[MSB], sum_im[MSB]);

  always_ff @(posedge clk) begin
    if (s3_vld) begin
      res_re <= s3_clr ? p_re : sum_re;
      res_im <= s3_clr ? p_im : sum_im;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ovf <= 1'b0;
    else if (s3_vld && (ovf_re || ovf_im)) ovf <= 1'b1;
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf); // R8

  AST_CLR_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    (s3_vld && s3_clr && !ovf) |=> !ovf); // R4

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (s3_vld && !s3_clr && s4_vld && (s3_addr == s4_addr))
      |=> (res_re == $past(res_re) + $past(p_re)) && (res_im == $past(res_im) + $past(p_im))); // R6
endmodule

// File: rtl/cca_channel.sv
module cca_channel
  import cca_pkg::*;
#(
  parameter int DW     = 8,
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_vld,
  input  logic                    in_clr,
  input  logic [ADDR_W-1:0]       in_addr,
  input  logic signed [DW-1:0]    a_re,
  input  logic signed [DW-1:0]    a_im,
  input  logic signed [DW-1:0]    b_re,
  input  logic signed [DW-1:0]    b_im,
  output logic                    res_vld,
  output logic [ADDR_W-1:0]       res_addr,
  output logic signed [ACC_W-1:0] res_re,
  output logic signed [ACC_W-1:0] res_im,
  output logic                    ovf
);
  // Valid reaches every stage; clear only the add stage; address the
  // read issue stage onward.
  localparam int VLO = 0;
  localparam int CLO = ST_CMB - 1;
  localparam int ALO = ST_MUL - 1;

  logic [ST_WB-VLO-1:0][0:0]        vld_t;
  logic [ST_CMB-CLO-1:0][0:0]       clr_t;
  logic [ST_WB-ALO-1:0][ADDR_W-1:0] adr_t;
  logic signed [ACC_W-1:0] p_re, p_im;

  cca_delay #(.W(1), .N(ST_WB), .LO(VLO)) u_vld (
    .clk(clk), .rst(rst), .d(in_vld), .q(vld_t));
  cca_delay #(.W(1), .N(ST_CMB), .LO(CLO)) u_clr (
    .clk(clk), .rst(rst), .d(in_clr), .q(clr_t));
  cca_delay #(.W(ADDR_W), .N(ST_WB), .LO(ALO)) u_adr (
    .clk(clk), .rst(rst), .d(in_addr), .q(adr_t));

  cca_prod #(.DW(DW), .ACC_W(ACC_W)) u_prod (
    .clk(clk),
    .in_en(in_vld),
    .s1_en(vld_t[ST_IN-1-VLO][0]),
    .s2_en(vld_t[ST_MUL-1-VLO][0]),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .p_re(p_re), .p_im(p_im));

  cca_accum #(.ADDR_W(ADDR_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst),
    .rd_addr(adr_t[ST_MUL-1-ALO]),
    .s3_vld(vld_t[ST_CMB-1-VLO][0]),
    .s3_clr(clr_t[ST_CMB-1-CLO][0]),
    .s3_addr(adr_t[ST_CMB-1-ALO]),
    .p_re(p_re), .p_im(p_im),
    .s4_vld(vld_t[ST_ACC-1-VLO][0]),
    .s4_addr(adr_t[ST_ACC-1-ALO]),
    .s5_vld(vld_t[ST_WB-1-VLO][0]),
    .s5_addr(adr_t[ST_WB-1-ALO]),
    .res_re(res_re), .res_im(res_im), .ovf(ovf));

  assign res_vld  = vld_t[ST_ACC-1-VLO][0];
  assign res_addr = adr_t[ST_ACC-1-ALO];

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> ##3 res_vld); // R2

  AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ##3 !res_vld); // R10
endmodule

// File: rtl/cplx_corr_acc.sv
module cplx_corr_acc #(
  parameter int NCH    = 2,
  parameter int DW     = 8,
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 10
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NCH-1:0]                in_vld,
  input  logic [NCH-1:0]                in_clr,
  input  logic [NCH-1:0][ADDR_W-1:0]    in_addr,
  input  logic [NCH-1:0][DW-1:0]        in_a_re,
  input  logic [NCH-1:0][DW-1:0]        in_a_im,
  input  logic [NCH-1:0][DW-1:0]        in_b_re,
  input  logic [NCH-1:0][DW-1:0]        in_b_im,
  output logic [NCH-1:0]                res_vld,
  output logic [NCH-1:0][ADDR_W-1:0]    res_addr,
  output logic [NCH-1:0][ACC_W-1:0]     res_re,
  output logic [NCH-1:0][ACC_W-1:0]     res_im,
  output logic [NCH-1:0]                ovf_flag
);
  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic signed [ACC_W-1:0] ch_re, ch_im;

      cca_channel #(.DW(DW), .ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_ch (
        .clk(clk), .rst(rst),
        .in_vld(in_vld[g]), .in_clr(in_clr[g]), .in_addr(in_addr[g]),
        .a_re($signed(in_a_re[g])), .a_im($signed(in_a_im[g])),
        .b_re($signed(in_b_re[g])), .b_im($signed(in_b_im[g])),
        .res_vld(res_vld[g]), .res_addr(res_addr[g]),
        .res_re(ch_re), .res_im(ch_im), .ovf(ovf_flag[g]));

      assign res_re[g] = ch_re;
      assign res_im[g] = ch_im;
    end
  endgenerate
endmodule

// File: tb/cplx_corr_acc_tb_top.sv
module cplx_corr_acc_tb_top;
  localparam int NCH = 2, DW = 8, ACC_W = 20, ADDR_W = 4;
  localparam int NADR = 1 << ADDR_W;
  localparam int NSL = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;  // 20 ns period

  logic [NCH-1:0]             in_vld = '0, in_clr = '0;
  logic [NCH-1:0][ADDR_W-1:0] in_addr = '0;
  logic [NCH-1:0][DW-1:0]     in_a_re = '0, in_a_im = '0, in_b_re = '0, in_b_im = '0;
  logic [NCH-1:0]             res_vld, ovf_flag;
  logic [NCH-1:0][ADDR_W-1:0] res_addr;
  logic [NCH-1:0][ACC_W-1:0]  res_re, res_im;

  cplx_corr_acc #(.NCH(NCH), .DW(DW), .ACC_W(ACC_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_clr(in_clr), .in_addr(in_addr),
    .in_a_re(in_a_re), .in_a_im(in_a_im), .in_b_re(in_b_re), .in_b_im(in_b_im),
    .res_vld(res_vld), .res_addr(res_addr), .res_re(res_re), .res_im(res_im),
    .ovf_flag(ovf_flag));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  // Sequential reference model
  int mdl_re [NCH][NADR];
  int mdl_im [NCH][NADR];
  bit ovf_mdl [NCH];
  bit ovf_exp [NCH];

  // Expected results by the cycle they appear in
  bit    sl_p    [NCH][NSL];
  int    sl_addr [NCH][NSL];
  int    sl_re   [NCH][NSL];
  int    sl_im   [NCH][NSL];
  bit    sl_ovf  [NCH][NSL];
  string sl_tag  [NCH][NSL];

  // Inputs staged for the next cycle
  bit    st_v [NCH];
  bit    st_c [NCH];
  int    st_addr [NCH];
  int    st_ar [NCH], st_ai [NCH], st_br [NCH], st_bi [NCH];
  string st_tag [NCH];

  function automatic int wrapw(input int x);
    logic [ACC_W-1:0] t;
    t = x[ACC_W-1:0];
    return int'($signed(t));
  endfunction

  function automatic bit out_of_range(input int x);
    return (x > (2 ** (ACC_W - 1)) - 1) || (x < -(2 ** (ACC_W - 1)));
  endfunction

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic put(input int ch, input bit v, input bit c, input int addr,
                     input int ar, input int ai, input int br, input int bi,
                     input string tag);
    st_v[ch] = v;  st_c[ch] = c;  st_addr[ch] = addr;
    st_ar[ch] = ar; st_ai[ch] = ai; st_br[ch] = br; st_bi[ch] = bi;
    st_tag[ch] = tag;
  endtask

  task automatic step();
    @(negedge clk);
    for (int ch = 0; ch < NCH; ch++) begin
      int slot, act_re, act_im;
      slot = cyc % NSL;
      act_re = int'($signed(res_re[ch]));
      act_im = int'($signed(res_im[ch]));
      if (sl_p[ch][slot]) begin
        chk(res_vld[ch] && (int'(res_addr[ch]) == sl_addr[ch][slot]) &&
            (act_re == sl_re[ch][slot]) && (act_im == sl_im[ch][slot]),
            $sformatf("%s ch%0d result: vld=%0b addr=%0d re=%0d im=%0d, expected vld=1 addr=%0d re=%0d im=%0d",
                      sl_tag[ch][slot], ch, res_vld[ch], res_addr[ch], act_re, act_im,
                      sl_addr[ch][slot], sl_re[ch][slot], sl_im[ch][slot]));
        ovf_exp[ch] = sl_ovf[ch][slot];
      end else begin
        chk(!res_vld[ch], $sformatf("R10 ch%0d stray result: vld=%0b, expected 0", ch, res_vld[ch]));
      end
      chk(ovf_flag[ch] == ovf_exp[ch],
          $sformatf("R8 ch%0d overflow flag: got %0b, expected %0b", ch, ovf_flag[ch], ovf_exp[ch]));
      sl_p[ch][slot] = 1'b0;
    end
    for (int ch = 0; ch < NCH; ch++) begin
      in_vld[ch]  = st_v[ch];
      in_clr[ch]  = st_c[ch];
      in_addr[ch] = ADDR_W'(st_addr[ch]);
      in_a_re[ch] = DW'(st_ar[ch]);
      in_a_im[ch] = DW'(st_ai[ch]);
      in_b_re[ch] = DW'(st_br[ch]);
      in_b_im[ch] = DW'(st_bi[ch]);
      if (st_v[ch]) begin
        int pr, pi, nr, ni, slot;
        pr = st_ar[ch] * st_br[ch] + st_ai[ch] * st_bi[ch];
        pi = st_ai[ch] * st_br[ch] - st_ar[ch] * st_bi[ch];
        if (st_c[ch]) begin
          nr = pr; ni = pi;
        end else begin
          nr = mdl_re[ch][st_addr[ch]] + pr;
          ni = mdl_im[ch][st_addr[ch]] + pi;
          if (out_of_range(nr) || out_of_range(ni)) ovf_mdl[ch] = 1'b1;
        end
        mdl_re[ch][st_addr[ch]] = wrapw(nr);
        mdl_im[ch][st_addr[ch]] = wrapw(ni);
        slot = (cyc + 4) % NSL;
        sl_p[ch][slot]    = 1'b1;
        sl_addr[ch][slot] = st_addr[ch];
        sl_re[ch][slot]   = wrapw(nr);
        sl_im[ch][slot]   = wrapw(ni);
        sl_ovf[ch][slot]  = ovf_mdl[ch];
        sl_tag[ch][slot]  = st_tag[ch];
      end
      put(ch, 1'b0, 1'b0, 0, 0, 0, 0, 0, "");
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    in_vld = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int ch = 0; ch < NCH; ch++) begin
      for (int s = 0; s < NSL; s++) sl_p[ch][s] = 1'b0;
      ovf_mdl[ch] = 1'b0;
      ovf_exp[ch] = 1'b0;
      chk(!res_vld[ch] && !ovf_flag[ch],
          $sformatf("R1 ch%0d after reset: vld=%0b ovf=%0b, expected 0 0", ch, res_vld[ch], ovf_flag[ch]));
    end
  endtask

  task automatic t_formula();  // R3 sign handling, R4 clear reloads
    put(0, 1, 1, 0, 3, -5, 7, 2, "R3");            step();
    put(0, 1, 1, 1, -128, 127, -128, -128, "R3");  step();
    put(0, 1, 1, 2, 127, 127, 127, -128, "R3");    step();
    put(0, 1, 1, 3, -128, -128, -128, -128, "R3"); step();
    idle(5);
    put(0, 1, 1, 1, 10, 20, 30, 40, "R4");         step();
    idle(5);
  endtask

  task automatic t_accum();  // R5 via memory read path
    put(0, 1, 0, 0, 1, 2, 3, 4, "R5");    step();
    idle(3);
    put(0, 1, 0, 0, -7, 5, 6, -9, "R5");  step();
    idle(2);
    put(0, 1, 0, 0, 9, -3, -2, 8, "R5");  step();
    idle(5);
  endtask

  task automatic t_b2b();  // R6 distance one and two
    put(0, 1, 1, 5, 4, 3, 2, 1, "R6");     step();
    put(0, 1, 0, 5, -6, 7, 8, -9, "R6");   step();
    put(0, 1, 0, 5, 11, 12, -13, 14, "R6"); step();
    put(0, 1, 0, 5, -1, -1, -1, -1, "R6"); step();
    put(0, 1, 1, 6, 5, 5, 5, 5, "R6");     step();
    put(0, 1, 1, 7, -5, 6, 7, 8, "R6");    step();
    for (int i = 0; i < 4; i++) begin
      put(0, 1, 0, 6 + (i % 2), i + 1, -i, 3, i - 2, "R6");
      step();
    end
    idle(5);
  endtask

  task automatic t_stream();  // R7 full rate, distinct addresses
    for (int i = 8; i < 16; i++) begin
      put(0, 1, 1, i, i, -i, 2 * i, 3, "R7");
      step();
    end
    for (int i = 8; i < 16; i++) begin
      put(0, 1, 0, i, -i, 5, i, -2 * i, "R7");
      step();
    end
    idle(5);
  endtask

  task automatic t_idle();  // R10 invalid cycles touch nothing
    put(0, 0, 1, 0, 100, 100, 100, 100, "R10"); step();
    put(0, 0, 0, 0, -90, 90, 90, -90, "R10");   step();
    put(0, 0, 1, 0, 77, 77, 77, 77, "R10");     step();
    put(0, 1, 0, 0, 1, 1, 1, 1, "R10");         step();
    idle(5);
  endtask

  task automatic t_dual();  // R9 same address on both channels
    for (int i = 0; i < 4; i++) begin
      put(0, 1, 0, 2, 3 + i, -4, 5, i, "R9");
      put(1, 1, (i == 0), 2, -20, 30 - i, 40, -50, "R9");
      step();
    end
    idle(5);
  endtask

  task automatic t_ovf();  // R8 overflow on ch0 only, R9 ch1 unaffected
    put(0, 1, 1, 9, -128, -128, -128, -128, "R8");
    put(1, 1, 1, 9, 1, 0, 1, 0, "R9");
    step();
    for (int i = 0; i < 17; i++) begin
      put(0, 1, 0, 9, -128, -128, -128, -128, "R8");
      put(1, 1, 0, 9, 1, 0, 1, 0, "R9");
      step();
    end
    idle(5);
  endtask

  initial begin
    for (int ch = 0; ch < NCH; ch++) put(ch, 1'b0, 1'b0, 0, 0, 0, 0, 0, "");
    t_reset();
    t_formula();
    t_accum();
    t_b2b();
    t_stream();
    t_idle();
    t_dual();
    t_ovf();
    t_reset();  // R1 also clears a set overflow flag
    idle(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule